// File: doc/BRIEF.md
# Tick-Clocked PWM Channel

A single-channel constant-frequency pulse-width modulator. An external variable-frequency time base supplies two signals: a one-cycle tick pulse and a square wave. The channel counter moves forward only on a tick. Each output period lasts `period + 1` ticks, and the output is high for the first `on` ticks of each period. If `on` is larger than `period`, the output stays high all the time.

A 4-bit control word sets four things: whether the counter runs, whether the pad driver is enabled, whether the output is forced high, and whether the pad works in open-drain or push-pull mode. A separate select bit picks what reaches the output stage: the PWM waveform, or the square wave passed through unchanged. New `on` and `period` values take effect at the next period boundary, so a pulse is never cut short. While the counter is stopped, new values are taken at once.

Top module: `pwm_tick_channel`

## Requirements
- R1: After reset the control word is start=0, oe_n=1, force=0, open_drain=0, and select is 0. So `pad_oe_o` is 0 and `pad_o` follows `sq_i`.
- R2: Control word bit positions are: bit0 start, bit1 output-enable-bar, bit2 force high, bit3 open drain. A write through `ctrl_we_i` takes effect from the next clock cycle.
- R3: With start set, the counter moves forward by one only in a cycle where `tick_i` is high. It wraps to 0 after reaching `period`. The PWM signal is high while the count is below `on`, which gives `on` high ticks in every `period + 1` ticks.
- R4: If `on` is greater than `period` (for example on=0xFF, period=0xFE), the PWM signal is high continuously.
- R5: While start is clear, the counter is held at 0 and the PWM signal is low.
- R6: A value written to `on` or `period` while the counter runs is first used after the tick that wraps the counter. While stopped, it is used from the next cycle.
- R7: With select=1 the output stage takes the PWM signal. With select=0 it takes `sq_i`.
- R8: With force high set, the selected signal is replaced by 1.
- R9: In open-drain mode `pad_o` is 0, and `pad_oe_o` is 1 only when oe_n is 0 and the selected signal is 0.
- R10: In push-pull mode `pad_o` equals the selected signal and `pad_oe_o` equals the inverse of oe_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| sq_i | input | 1 | Time-base square wave |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 4 | Control word write data |
| sel_we_i | input | 1 | Select bit write strobe |
| sel_i | input | 1 | Select bit write data |
| on_we_i | input | 1 | On-count write strobe |
| per_we_i | input | 1 | Period-count write strobe |
| val_i | input | CNT_W | Count write data |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad driver enable |

## Verification
The bench uses the default 8-bit count width. This makes the full-scale pair on=0xFF, period=0xFE reachable in a short run, so the always-high case and the wrap at the top code are both tested. Ticks arrive every cycle in some phases and every third cycle in others, so the bench can confirm that cycles without a tick leave the counter unchanged. New values are written in the middle of a period to check that they are held back until the wrap.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  typedef struct packed {
    logic od;        // bit3
    logic force_hi;  // bit2
    logic oe_n;      // bit1
    logic start;     // bit0
  } pwm_ctrl_t;

  localparam pwm_ctrl_t CTRL_RST = '{od: 1'b0, force_hi: 1'b0, oe_n: 1'b1, start: 1'b0};
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_tick_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ctrl_we_i,
  input  logic [3:0] ctrl_i,
  input  logic      sel_we_i,
  input  logic      sel_i,
  output pwm_ctrl_t ctrl_o,
  output logic      sel_o
);
  pwm_ctrl_t ctrl_q;
  logic      sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      sel_q  <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= pwm_ctrl_t'(ctrl_i);
      if (sel_we_i)  sel_q  <= sel_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o == pwm_ctrl_t'($past(ctrl_i))));
  a_r2_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             on_we_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] on_sh_q, per_sh_q, on_q, per_q, cnt_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_sh_q  <= '0;
      per_sh_q <= '0;
    end else begin
      if (on_we_i)  on_sh_q  <= val_i;
      if (per_we_i) per_sh_q <= val_i;
    end
  end

  // active values reload only at a period boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= '0;
      per_q <= '0;
    end else if (!start_i) begin
      cnt_q <= '0;
      on_q  <= on_sh_q;
      per_q <= per_sh_q;
    end else if (wrap) begin
      cnt_q <= '0;
      on_q  <= on_sh_q;
      per_q <= per_sh_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign pwm_o = start_i && (cnt_q < on_q);

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_q <= per_q));
  a_r3_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !tick_i) |=> $stable(cnt_q));
  a_r4_full_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (on_q > per_q)) |-> pwm_o);
  a_r5_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (cnt_q == '0));
  a_r5_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> !pwm_o);
  a_r6_hold_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wrap) |=> ($stable(on_q) && $stable(per_q)));
endmodule

// File: rtl/pwm_pad_stage.sv
module pwm_pad_stage
  import pwm_tick_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwm_ctrl_t ctrl_i,
  input  logic      sel_i,
  input  logic      pwm_i,
  input  logic      sq_i,
  output logic      pad_o,
  output logic      pad_oe_o
);
  logic src, drv;

  always_comb begin
    src = sel_i ? pwm_i : sq_i;
    drv = ctrl_i.force_hi ? 1'b1 : src;
    if (ctrl_i.od) begin
      pad_o    = 1'b0;
      pad_oe_o = !ctrl_i.oe_n && !drv;
    end else begin
      pad_o    = drv;
      pad_oe_o = !ctrl_i.oe_n;
    end
  end

  a_r9_od_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.od |-> !pad_o);
  a_r9_od_force_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.od && ctrl_i.force_hi) |-> !pad_oe_o);
  a_r10_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.oe_n |-> !pad_oe_o);
  a_r8_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.force_hi && !ctrl_i.od) |-> pad_o);
  a_r7_sq_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !ctrl_i.force_hi && !ctrl_i.od) |-> (pad_o == sq_i));
endmodule

// File: rtl/pwm_tick_channel.sv
module pwm_tick_channel
  import pwm_tick_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sq_i,
  input  logic             ctrl_we_i,
  input  logic [3:0]       ctrl_i,
  input  logic             sel_we_i,
  input  logic             sel_i,
  input  logic             on_we_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             pad_o,
  output logic             pad_oe_o
);
  pwm_ctrl_t ctrl;
  logic      sel, pwm;

  pwm_ctrl_regs u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_i, .sel_we_i, .sel_i,
    .ctrl_o(ctrl), .sel_o(sel)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .start_i(ctrl.start),
    .on_we_i, .per_we_i, .val_i, .pwm_o(pwm)
  );

  pwm_pad_stage u_pad (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .sel_i(sel), .pwm_i(pwm), .sq_i,
    .pad_o, .pad_oe_o
  );

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!pad_oe_o && (pad_o == sq_i)));
endmodule

// File: tb/pwm_tick_channel_tb_top.sv
module pwm_tick_channel_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, sq = 1'b0;
  logic ctrl_we = 1'b0, sel_we = 1'b0, on_we = 1'b0, per_we = 1'b0;
  logic [3:0] ctrl_d = '0;
  logic sel_d = 1'b0;
  logic [CNT_W-1:0] val = '0;
  logic pad, pad_oe;

  int checks = 0, errors = 0;
  int tick_div = 0;  // 0 = no ticks
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_start, m_oeb, m_force, m_od, m_sel, m_on_sh, m_per_sh, m_on, m_per, m_cnt;

  always #2 clk = ~clk;

  pwm_tick_channel #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sq_i(sq),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl_d), .sel_we_i(sel_we), .sel_i(sel_d),
    .on_we_i(on_we), .per_we_i(per_we), .val_i(val),
    .pad_o(pad), .pad_oe_o(pad_oe)
  );

  function automatic void model_reset();
    m_start = 0; m_oeb = 1; m_force = 0; m_od = 0; m_sel = 0;
    m_on_sh = 0; m_per_sh = 0; m_on = 0; m_per = 0; m_cnt = 0;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (m_start == 0) begin
        m_cnt = 0; m_on = m_on_sh; m_per = m_per_sh;
      end else if (tick) begin
        if (m_cnt == m_per) begin
          m_cnt = 0; m_on = m_on_sh; m_per = m_per_sh;
        end else m_cnt++;
      end
      if (ctrl_we) begin
        m_start = ctrl_d[0]; m_oeb = ctrl_d[1]; m_force = ctrl_d[2]; m_od = ctrl_d[3];
      end
      if (sel_we) m_sel = sel_d;
      if (on_we)  m_on_sh = val;
      if (per_we) m_per_sh = val;
    end
  end

  task automatic check(string req, logic act_pad, logic act_oe, logic exp_pad, logic exp_oe);
    checks++;
    if (act_pad !== exp_pad || act_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: pad/oe actual %b/%b expected %b/%b at %0t",
               req, act_pad, act_oe, exp_pad, exp_oe, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int pwm, sig, e_pad, e_oe;
      pwm = (m_start != 0 && m_cnt < m_on) ? 1 : 0;
      sig = m_force ? 1 : (m_sel ? pwm : int'(sq));
      if (m_od) begin e_pad = 0; e_oe = (!m_oeb && !sig) ? 1 : 0; end
      else      begin e_pad = sig; e_oe = m_oeb ? 0 : 1; end
      check(cur_req, pad, pad_oe, e_pad[0], e_oe[0]);
    end
  end

  // tick and square-wave generators
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick = (tick_div != 0) && (c % tick_div == 0);
      if (c % 5 == 0) sq = ~sq;
    end
  end

  task automatic wr_ctrl(logic [3:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_d = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_sel(logic v);
    @(negedge clk); sel_we = 1; sel_d = v;
    @(negedge clk); sel_we = 0;
  endtask
  task automatic wr_cnt(logic [CNT_W-1:0] on_v, logic [CNT_W-1:0] per_v);
    @(negedge clk); on_we = 1; val = on_v;
    @(negedge clk); on_we = 0; per_we = 1; val = per_v;
    @(negedge clk); per_we = 0;
  endtask
  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    run(12);
    // R2: write oe_n=0 only, pad enable must appear the next cycle
    cur_req = "R2";
    @(negedge clk); ctrl_we = 1; ctrl_d = 4'b0000;
    @(negedge clk); ctrl_we = 0;
    #2 check("R2", pad, pad_oe, sq, 1'b1);
    wr_ctrl(4'b0010);
    #2 check("R2", pad, pad_oe, sq, 1'b0);
    // R3/R9: open-drain PWM, sparse ticks
    cur_req = "R3";
    wr_sel(1'b1);
    wr_cnt(8'd3, 8'd7);
    tick_div = 3;
    wr_ctrl(4'b1001);
    run(120);
    cur_req = "R9";
    run(60);
    // R10: push-pull, tick every cycle
    cur_req = "R10";
    tick_div = 1;
    wr_ctrl(4'b0001);
    run(40);
    // R6: new values mid-period
    cur_req = "R6";
    run(3);
    wr_cnt(8'd5, 8'd9);
    run(60);
    // R4: full-on with maximal codes
    cur_req = "R4";
    wr_cnt(8'hFF, 8'hFE);
    run(600);
    wr_cnt(8'd0, 8'd4);
    run(20);
    // R8: force high in push-pull, then in open drain
    cur_req = "R8";
    wr_ctrl(4'b0101);
    run(20);
    wr_ctrl(4'b1101);
    run(20);
    // R7: square wave selected
    cur_req = "R7";
    wr_cnt(8'd2, 8'd6);
    wr_ctrl(4'b0001);
    wr_sel(1'b0);
    run(40);
    wr_ctrl(4'b1001);
    run(30);
    // R5: stop; counter resets, pwm low, values taken immediately
    cur_req = "R5";
    wr_sel(1'b1);
    wr_ctrl(4'b0000);
    run(20);
    wr_cnt(8'd1, 8'd2);
    run(5);
    wr_ctrl(4'b0001);
    run(30);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule